// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block places a small direct-mapped data cache between a processor word port and a 64-bit memory bus. Storage is organised as whole 64-byte lines; a line is either fully present or absent, never partly filled. A 32-bit request address is cut into a byte offset (low 6 bits), a set index (next `SET_BITS` bits) and a tag (everything above). Reads and writes that hit are served from the line store. A miss of either kind loads the complete line in an 8-beat burst. If the slot holds a modified line, that line goes back to memory before the new one comes in. Writes merge one 32-bit word under byte enables and mark the line modified.

The processor holds `cpu_req` with a stable address, direction, data and byte enables until it sees `cpu_ready`. `cpu_ready` is a one-cycle pulse, and `cpu_rdata` is valid during it. The memory side raises `mem_req` with a line-aligned `mem_addr` and the direction on `mem_we`. Each cycle in which memory returns `mem_ack` moves one 64-bit beat: memory consumes `mem_wdata` for a write, or the cache captures `mem_rdata` for a read. Beats run in ascending order from offset 0.

The controller has four states. LOOKUP compares tags while a request is pending. RESP drives the response pulse. EVICT copies a modified victim out. REFILL loads the new line. The transitions are:
- `hit`: LOOKUP to RESP.
- `miss_clean`: LOOKUP to REFILL, when the slot is empty or unmodified.
- `miss_dirty`: LOOKUP to EVICT.
- `evict_done`: EVICT to REFILL, on the eighth acknowledged beat.
- `fill_done`: REFILL to LOOKUP, on the eighth acknowledged beat. The lookup is then retried and now hits.
- `resp_done`: RESP to LOOKUP.

Top module: `wb_line_cache`

## Requirements
- R1: Address bits [5:0] are the byte offset, bits [9:6] are the set index (with the default `SET_BITS`=4), and bits [31:10] are the tag. Two addresses with the same set bits and different tags occupy the same slot and displace each other.
- R2: After reset every line is invalid, so the first access to any set is a miss. `cpu_ready` and `mem_req` are low after reset.
- R3: A read or write hit raises `cpu_ready` one cycle after the request is seen, and causes no bus activity.
- R4: A fill is one burst of exactly 8 acknowledged beats with `mem_we`=0. `mem_addr` is the request address with bits [5:0] zeroed. Beat k carries line bytes 8k..8k+7, least significant byte first. Within a beat, the word at address bit 2 = 1 is the upper 32 bits.
- R5: On a miss, `cpu_ready` is not raised until all 8 beats of the fill have been accepted. The returned word is the one from the fetched line.
- R6: A write miss loads the whole line first and then merges the written word. The other words of that line keep the values they had in memory.
- R7: On a write, bit i of `cpu_be` enables byte i (bits 8i+7..8i) of the addressed word. Disabled bytes are unchanged.
- R8: A write marks its line modified. When a modified line is displaced, it is first sent as an 8-beat burst with `mem_we`=1 to its own line-aligned address, carrying the current contents. Only after that does the fill of the new line start. After this writeback the slot no longer counts as modified.
- R9: Displacing a line that was never written, or that was freshly filled after a writeback, produces no write burst.
- R10: `cpu_ready` is high for exactly one cycle per request. In the cycle after the pulse the request lines are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Request pending, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the word |
| cpu_be | input | 4 | Byte enables for writes |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Burst in progress |
| mem_we | output | 1 | 1 = writeback burst, 0 = fill burst |
| mem_addr | output | 32 | Line-aligned burst address |
| mem_wdata | output | 64 | Writeback beat data |
| mem_ack | input | 1 | One beat transferred this cycle |
| mem_rdata | input | 64 | Fill beat data |

## Verification
A wrong valid bit or tag shows at the ports on the very next access to that set: either a burst appears where a one-cycle hit was expected, or a one-cycle hit returns stale data. A lost or spurious modified flag stays hidden until the slot is displaced. It then shows as a missing or extra write burst, or as memory contents that lose a written word when the line is read back later. The test therefore evicts and reloads lines and compares the memory image word by word after each writeback. A beat counter that slips shows as a burst longer or shorter than 8 beats, or as data shifted between neighbouring words.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP,
        ST_RESP,
        ST_EVICT,
        ST_REFILL
    } wbc_state_e;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
    parameter int SET_BITS = 4,
    parameter int TAG_W    = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_BITS-1:0] set_idx,
    input  logic                install,
    input  logic [TAG_W-1:0]    install_tag,
    input  logic                mark_dirty,
    input  logic                mark_clean,
    output logic                line_valid,
    output logic                line_dirty,
    output logic [TAG_W-1:0]    line_tag
);
    localparam int SETS = 1 << SET_BITS;

    logic [SETS-1:0]  valid_q;
    logic [SETS-1:0]  dirty_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (install) begin
                valid_q[set_idx] <= 1'b1;
                dirty_q[set_idx] <= 1'b0;
            end else if (mark_dirty) begin
                dirty_q[set_idx] <= 1'b1;
            end else if (mark_clean) begin
                dirty_q[set_idx] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (install) tag_q[set_idx] <= install_tag;
    end

    assign line_valid = valid_q[set_idx];
    assign line_dirty = dirty_q[set_idx];
    assign line_tag   = tag_q[set_idx];

    // R8: a modified flag only ever sits on a valid line
    p_dirty_implies_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/wbc_line_store.sv
module wbc_line_store #(
    parameter int SET_BITS = 4,
    parameter int BEAT_W   = 3,
    parameter int BUS_W    = 64
) (
    input  logic                       clk,
    input  logic [SET_BITS-1:0]        set_idx,
    input  logic                       fill_en,
    input  logic [BEAT_W-1:0]          fill_beat,
    input  logic [BUS_W-1:0]           fill_data,
    input  logic                       word_en,
    input  logic [BEAT_W-1:0]          word_beat,
    input  logic [$clog2(BUS_W/32)-1:0] word_sel,
    input  logic [3:0]                 word_be,
    input  logic [31:0]                word_data,
    output logic [BUS_W-1:0]           word_beat_data,
    input  logic [BEAT_W-1:0]          drain_beat,
    output logic [BUS_W-1:0]           drain_data
);
    localparam int ENTRIES = (1 << SET_BITS) << BEAT_W;

    logic [BUS_W-1:0] beat_mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (fill_en) begin
            beat_mem[{set_idx, fill_beat}] <= fill_data;
        end else if (word_en) begin
            for (int b = 0; b < 4; b++) begin
                if (word_be[b])
                    beat_mem[{set_idx, word_beat}][int'(word_sel)*32 + b*8 +: 8]
                        <= word_data[b*8 +: 8];
            end
        end
    end

    assign word_beat_data = beat_mem[{set_idx, word_beat}];
    assign drain_data     = beat_mem[{set_idx, drain_beat}];
endmodule

// File: rtl/wb_line_cache.sv
module wb_line_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SET_BITS   = 4,
    parameter int LINE_BYTES = 64,
    parameter int BUS_W      = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [3:0]        cpu_be,
    input  logic [31:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic [31:0]       cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BUS_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [BUS_W-1:0]  mem_rdata
);
    localparam int OFS_W  = $clog2(LINE_BYTES);
    localparam int BEATS  = LINE_BYTES * 8 / BUS_W;
    localparam int BEAT_W = $clog2(BEATS);
    localparam int WSEL_W = $clog2(BUS_W / 32);
    localparam int TAG_W  = ADDR_W - SET_BITS - OFS_W;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

    wbc_state_e st_q, st_d;
    logic [BEAT_W-1:0] beat_q;
    logic [31:0]       rdata_q;

    logic [SET_BITS-1:0] req_set;
    logic [TAG_W-1:0]    req_tag;
    logic [BEAT_W-1:0]   req_beat;
    logic [WSEL_W-1:0]   req_wsel;

    assign req_set  = cpu_addr[OFS_W +: SET_BITS];
    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_beat = cpu_addr[OFS_W-1 -: BEAT_W];
    assign req_wsel = cpu_addr[2 +: WSEL_W];

    logic             tag_valid, tag_dirty;
    logic [TAG_W-1:0] tag_value;
    logic             hit, lookup_hit, beat_done, last_done;
    logic             do_install, do_dirty, do_clean, do_fill, do_word;
    logic [BUS_W-1:0] hit_beat_data, drain_data;

    assign hit        = tag_valid && (tag_value == req_tag);
    assign lookup_hit = (st_q == ST_LOOKUP) && cpu_req && hit;
    assign beat_done  = mem_req && mem_ack;
    assign last_done  = beat_done && (beat_q == LAST_BEAT);
    assign do_fill    = (st_q == ST_REFILL) && beat_done;
    assign do_install = (st_q == ST_REFILL) && last_done;
    assign do_clean   = (st_q == ST_EVICT) && last_done;
    assign do_word    = lookup_hit && cpu_we;
    assign do_dirty   = do_word;

    wbc_tag_store #(.SET_BITS(SET_BITS), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_idx    (req_set),
        .install    (do_install),
        .install_tag(req_tag),
        .mark_dirty (do_dirty),
        .mark_clean (do_clean),
        .line_valid (tag_valid),
        .line_dirty (tag_dirty),
        .line_tag   (tag_value)
    );

    wbc_line_store #(.SET_BITS(SET_BITS), .BEAT_W(BEAT_W), .BUS_W(BUS_W)) u_lines (
        .clk           (clk),
        .set_idx       (req_set),
        .fill_en       (do_fill),
        .fill_beat     (beat_q),
        .fill_data     (mem_rdata),
        .word_en       (do_word),
        .word_beat     (req_beat),
        .word_sel      (req_wsel),
        .word_be       (cpu_be),
        .word_data     (cpu_wdata),
        .word_beat_data(hit_beat_data),
        .drain_beat    (beat_q),
        .drain_data    (drain_data)
    );

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_LOOKUP: begin
                if (cpu_req) begin
                    if (hit)                         st_d = ST_RESP;   // hit
                    else if (tag_valid && tag_dirty) st_d = ST_EVICT;  // miss_dirty
                    else                             st_d = ST_REFILL; // miss_clean
                end
            end
            ST_RESP:   st_d = ST_LOOKUP;                              // resp_done
            ST_EVICT:  if (last_done) st_d = ST_REFILL;               // evict_done
            ST_REFILL: if (last_done) st_d = ST_LOOKUP;               // fill_done
            default:   st_d = ST_LOOKUP;
        endcase
    end

    // state register, beat counter, read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_LOOKUP;
            beat_q  <= '0;
            rdata_q <= '0;
        end else begin
            st_q <= st_d;
            if (beat_done) beat_q <= beat_q + 1'b1;
            if (lookup_hit) rdata_q <= hit_beat_data[int'(req_wsel)*32 +: 32];
        end
    end

    // outputs
    always_comb begin
        cpu_ready = (st_q == ST_RESP);
        cpu_rdata = rdata_q;
        mem_req   = (st_q == ST_EVICT) || (st_q == ST_REFILL);
        mem_we    = (st_q == ST_EVICT);
        mem_wdata = drain_data;
        if (st_q == ST_EVICT) mem_addr = {tag_value, req_set, {OFS_W{1'b0}}};
        else                  mem_addr = {req_tag,   req_set, {OFS_W{1'b0}}};
    end

    // R4: bursts always start at a line boundary
    p_line_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[OFS_W-1:0] == '0));

    // R10: the completion pulse lasts one cycle
    p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R8: no fill begins over a line that is still modified
    p_fill_over_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_REFILL && $stable(cpu_addr)) |-> !(tag_valid && tag_dirty));

    // R8: a completed write leaves its line modified
    p_write_marks_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && $past(cpu_we) && $stable(cpu_addr)) |-> tag_dirty);

    // R4: burst address and direction hold while beats are outstanding
    p_burst_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/tb_wb_line_cache.sv
module tb_wb_line_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata = '0;

    always #5 clk = ~clk;

    wb_line_cache dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // backing memory: untouched beats read as {~a, a}
    logic [63:0] mm [logic [31:0]];
    function automatic logic [63:0] mem_rd(input logic [31:0] a);
        if (mm.exists(a)) return mm[a];
        return {~a, a};
    endfunction

    // reference image of what the processor should see
    logic [31:0] refw [logic [31:0]];
    function automatic logic [31:0] ref_rd(input logic [31:0] a);
        logic [31:0] w = {a[31:2], 2'b00};
        logic [63:0] d;
        if (refw.exists(w)) return refw[w];
        d = {~{w[31:3], 3'b000}, {w[31:3], 3'b000}};
        return w[2] ? d[63:32] : d[31:0];
    endfunction

    // memory model with burst log
    int n_rd_burst = 0, n_wr_burst = 0;
    logic        log_we [$];
    logic [31:0] log_addr [$];
    int  bbeat = 0, gap_cnt = 0;
    bit  gaps = 0;
    always @(negedge clk) begin
        if (!mem_req) begin
            mem_ack = 1'b0;
            bbeat = 0;
        end else begin
            gap_cnt++;
            if (gaps && (gap_cnt % 3 == 0)) begin
                mem_ack = 1'b0;
            end else begin
                mem_ack = 1'b1;
                if (bbeat == 0) begin
                    log_we.push_back(mem_we);
                    log_addr.push_back(mem_addr);
                    if (mem_we) n_wr_burst++; else n_rd_burst++;
                end
                if (mem_we) mm[mem_addr + 32'(bbeat * 8)] = mem_wdata;
                else        mem_rdata = mem_rd(mem_addr + 32'(bbeat * 8));
                bbeat = (bbeat + 1) % 8;
            end
        end
    end

    // scoreboard
    typedef struct { bit is_rd; logic [31:0] exp; logic [31:0] addr; } item_t;
    item_t sb_q [$];
    always @(negedge clk) begin
        if (cpu_ready && !done) begin
            item_t it;
            if (sb_q.size() == 0) begin
                chk(1'b0, "R10 unexpected response", 64'(cpu_ready), 64'd0);
            end else begin
                it = sb_q.pop_front();
                if (it.is_rd)
                    chk(cpu_rdata == it.exp, "R4/R5 read data", 64'(cpu_rdata), 64'(it.exp));
            end
        end
    end

    int lat;
    task automatic cpu_op(input bit we, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        item_t it;
        logic [31:0] old;
        it.is_rd = !we; it.addr = a; it.exp = ref_rd(a);
        sb_q.push_back(it);
        if (we) begin
            old = ref_rd(a);
            for (int b = 0; b < 4; b++) if (be[b]) old[b*8 +: 8] = d[b*8 +: 8];
            refw[{a[31:2], 2'b00}] = old;
        end
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!cpu_ready);
        cpu_req = 1'b0;
        @(negedge clk);
        chk(!cpu_ready, "R10 ready one cycle", 64'(cpu_ready), 64'd0);
    endtask

    task automatic chk_line_in_mem(input logic [31:0] base, input string req);
        for (int k = 0; k < 16; k++) begin
            logic [63:0] d = mem_rd(base + 32'(k / 2 * 8));
            logic [31:0] w = (k % 2 == 1) ? d[63:32] : d[31:0];
            chk(w == ref_rd(base + 32'(k * 4)), req, 64'(w), 64'(ref_rd(base + 32'(k * 4))));
        end
    endtask

    localparam logic [31:0] A = 32'h0000_1040;
    localparam logic [31:0] B = 32'h0000_2040;
    localparam logic [31:0] C = 32'h0000_1080;
    localparam logic [31:0] E = 32'h0000_3100;
    localparam logic [31:0] F = 32'h0000_5100;

    int rb0, wb0;

    initial begin
        repeat (3) @(negedge clk);
        // R2: quiet after reset
        chk(!cpu_ready, "R2 ready low at reset", 64'(cpu_ready), 64'd0);
        chk(!mem_req, "R2 mem_req low at reset", 64'(mem_req), 64'd0);
        rst_n = 1'b1;

        // R2 R4 R5: first read misses, one aligned fill
        rb0 = n_rd_burst; wb0 = n_wr_burst;
        cpu_op(0, A + 32'h8, 0, 0);
        chk(n_rd_burst == rb0 + 1, "R2 first access fills", 64'(n_rd_burst - rb0), 64'd1);
        chk(n_wr_burst == wb0, "R9 empty slot no writeback", 64'(n_wr_burst - wb0), 64'd0);
        chk(log_addr[$] == A, "R1 R4 fill line address", 64'(log_addr[$]), 64'(A));
        chk(lat >= 9, "R5 miss waits for 8 beats", 64'(lat), 64'd9);

        // R3: hit on last word of line
        rb0 = n_rd_burst;
        cpu_op(0, A + 32'h3C, 0, 0);
        chk(lat == 1, "R3 hit latency", 64'(lat), 64'd1);
        chk(n_rd_burst == rb0, "R3 no bus on hit", 64'(n_rd_burst - rb0), 64'd0);

        // R7: partial byte write on hit
        cpu_op(1, A + 32'h10, 32'h1122_3344, 4'b0101);
        chk(lat == 1, "R3 write hit latency", 64'(lat), 64'd1);
        cpu_op(0, A + 32'h10, 0, 0);

        // R6: write miss allocates whole line
        rb0 = n_rd_burst;
        cpu_op(1, C + 32'h24, 32'hDEAD_BEEF, 4'b1111);
        chk(n_rd_burst == rb0 + 1, "R6 write miss fills", 64'(n_rd_burst - rb0), 64'd1);
        chk(lat >= 9, "R6 write waits for fill", 64'(lat), 64'd9);
        cpu_op(0, C + 32'h20, 0, 0);
        cpu_op(0, C + 32'h24, 0, 0);

        // R1 R8: conflicting tag evicts dirty line first
        rb0 = n_rd_burst; wb0 = n_wr_burst;
        cpu_op(0, B, 0, 0);
        chk(n_wr_burst == wb0 + 1, "R8 dirty victim written", 64'(n_wr_burst - wb0), 64'd1);
        chk(log_we[$-1] == 1'b1 && log_addr[$-1] == A, "R8 writeback first at victim",
            64'(log_addr[$-1]), 64'(A));
        chk(log_we[$] == 1'b0 && log_addr[$] == B, "R8 fill after writeback",
            64'(log_addr[$]), 64'(B));
        chk(lat >= 17, "R8 response after both bursts", 64'(lat), 64'd17);
        chk_line_in_mem(A, "R8 writeback contents");

        // R9: clean victim, line re-read from memory
        wb0 = n_wr_burst;
        cpu_op(0, A + 32'h10, 0, 0);
        chk(n_wr_burst == wb0, "R9 clean victim no writeback", 64'(n_wr_burst - wb0), 64'd0);
        cpu_op(0, B + 32'h4, 0, 0);
        chk(n_wr_burst == wb0, "R9 refilled line is clean", 64'(n_wr_burst - wb0), 64'd0);

        // gapped bus, several words and a dirty eviction
        gaps = 1;
        for (int i = 0; i < 16; i++)
            cpu_op(1, E + 32'(i * 4), 32'hA000_0000 + 32'(i), (i % 3 == 0) ? 4'b1000 : 4'b1111);
        wb0 = n_wr_burst;
        cpu_op(0, F + 32'h1C, 0, 0);
        chk(n_wr_burst == wb0 + 1, "R8 gapped writeback", 64'(n_wr_burst - wb0), 64'd1);
        chk_line_in_mem(E, "R7 R8 gapped line contents");
        for (int i = 0; i < 16; i++) cpu_op(0, E + 32'(i * 4), 0, 0);
        gaps = 0;

        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R10 all responses seen", 64'(sb_q.size()), 64'd0);
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule